// File: doc/BRIEF.md
# Compartment-Tagged Register File

A small register file for a processor that runs mutually distrusting protection compartments. Each register holds a data word and an ownership tag, which is the compartment ID that last wrote it. A current-compartment register holds the active ID. Enter and exit commands change it. Every read and write is checked against the target register's tag, and an access from the wrong compartment is refused.

Untrusted supervisor code still has to spill and reload registers when it handles a trap. A save command therefore turns one register into a sealed tuple:
- a ciphertext word;
- a 16-bit keyed check value;
- the owner ID.

A restore command verifies such a tuple and puts it back into a register. Sealing uses a per-compartment key taken from a small key table. On every interrupt all keys step to new values, so a tuple saved before an interrupt cannot be replayed after it.

A keyed XOR pad and a keyed additive checksum stand in for real ciphers. The key table also hands out fresh compartment IDs, for example when a child process needs an identity separate from its parent.

Top module: `ctr_regfile`

## Requirements
- R1: After synchronous reset the block is in the following state:
  - every register holds data 0 with tag 0;
  - the current ID is 0;
  - key-table entries 0 and 7 are valid and all others are free;
  - entry i holds the key 0x9E3779B9*(i+1) mod 2^32;
  - all pulse outputs are 0, and rd_data, sv_cipher, sv_hash, sv_owner and alloc_id are 0.
- R2: A command is sampled when cmd_valid is 1, with cmd_op taking these values: 1=READ, 2=WRITE, 3=ENTER, 4=EXIT, 5=SAVE, 6=RESTORE, 7=ALLOC and 0=no operation. A WRITE to a register whose tag is 0 or equals the current ID replaces both data and tag, with the new tag set to the current ID. Any other WRITE leaves the register unchanged and raises acc_fault for one cycle.
- R3: A READ of a register whose tag is 0 or equals the current ID returns its data on rd_data with rd_valid high for one cycle. A refused READ raises rd_valid and acc_fault together and returns 0.
- R4: ENTER with a cmd_id that is nonzero and valid in the key table sets the current ID to cmd_id. ENTER with any other cmd_id is ignored. EXIT sets the current ID to 0.
- R5: SAVE is allowed from any compartment. It looks up key k for the register's tag t. It then outputs, with sv_valid high for one cycle:
  - sv_cipher = data XOR k;
  - sv_owner = t;
  - sv_hash = ((data[31:16] XOR k[15:0]) + (data[15:0] XOR k[31:16])) mod 2^16, XOR (t shifted left by 5).
- R6: RESTORE takes cmd_data as the ciphertext, cmd_id as the owner and cmd_hash as the check value. It forms plain = cmd_data XOR key[cmd_id] and recomputes the R5 hash for that plaintext, owner and key. If the result equals cmd_hash, the register takes data plain and tag cmd_id. Otherwise the register is unchanged and integ_fault pulses for one cycle.
- R7: When irq is 1 at a clock edge, every key k becomes (k rotated left by 1) XOR 0x9E3779B9. A command in the same cycle uses the old keys. A tuple saved before the interrupt then fails restore.
- R8: ALLOC marks the lowest-numbered free key-table entry as valid, pulses alloc_ok and sets alloc_id to that entry's index. kt_full is high whenever all 8 entries are valid. ALLOC while the table is full changes nothing and gives no alloc_ok.
- R9: Every output reflects the command sampled at the previous rising edge and does not change before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (R2) |
| cmd_reg | input | 3 | Register index |
| cmd_id | input | 3 | Compartment ID for ENTER and RESTORE |
| cmd_data | input | 32 | Write data, or ciphertext for RESTORE |
| cmd_hash | input | 16 | Check value for RESTORE |
| irq | input | 1 | Interrupt; renews all keys |
| cur_id | output | 3 | Current compartment ID |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 32 | Read data |
| acc_fault | output | 1 | Refused access pulse |
| sv_valid | output | 1 | Save result pulse |
| sv_cipher | output | 32 | Sealed data word |
| sv_hash | output | 16 | Check value of saved tuple |
| sv_owner | output | 3 | Owner ID of saved tuple |
| integ_fault | output | 1 | Restore check failure pulse |
| alloc_ok | output | 1 | Allocation success pulse |
| alloc_id | output | 3 | Most recently allocated ID |
| kt_full | output | 1 | All key-table entries in use |

## Verification
Every result of a command is due one clock after the edge that sampled the command. This covers read data, faults, sealed tuples, the current ID, allocation results and key renewal. The bench drives inputs on the falling edge and steps a behavioural reference model right after the rising edge. It compares every output with the model at the next falling edge, so each comparison lands in the cycle where the registered output is due. A separate check samples between the driving edge and the next rising edge to confirm that an output has not yet moved.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_ENTER   = 3'd3,
    OP_EXIT    = 3'd4,
    OP_SAVE    = 3'd5,
    OP_RESTORE = 3'd6,
    OP_ALLOC   = 3'd7
  } op_t;

  // Constant used both for reset keys and for per-interrupt key stepping.
  localparam logic [31:0] KEY_STEP = 32'h9E3779B9;
endpackage

// File: rtl/ctr_key_table.sv
module ctr_key_table
  import ctr_pkg::*;
#(
  parameter int NID    = 8,
  parameter int DW     = 32,
  parameter int SUP_ID = 7,
  parameter int IDW    = $clog2(NID)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           irq,
  input  logic           alloc_req,
  input  logic [IDW-1:0] lk_id,
  output logic [DW-1:0]  lk_key,
  output logic [NID-1:0] valid,
  output logic           alloc_hit,
  output logic [IDW-1:0] alloc_slot,
  output logic           full
);
  logic [DW-1:0]  key_q [NID];
  logic [NID-1:0] valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NID; i++) key_q[i] <= DW'(KEY_STEP * 32'(i + 1));
      valid_q <= NID'(1) | (NID'(1) << SUP_ID);
    end else begin
      if (irq)
        for (int i = 0; i < NID; i++)
          key_q[i] <= {key_q[i][DW-2:0], key_q[i][DW-1]} ^ DW'(KEY_STEP);
      if (alloc_req && alloc_hit) valid_q[alloc_slot] <= 1'b1;
    end
  end

  // Lowest-numbered free entry wins.
  always_comb begin
    alloc_hit  = 1'b0;
    alloc_slot = '0;
    for (int i = NID - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        alloc_hit  = 1'b1;
        alloc_slot = IDW'(i);
      end
  end

  assign lk_key = key_q[lk_id];
  assign valid  = valid_q;
  assign full   = &valid_q;

  // Keys move only on an interrupt edge.
  p_keys_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !irq |=> $stable(key_q[0]));
  // Once an entry is handed out it stays in use.
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    valid_q[0] |=> valid_q[0]);
endmodule

// File: rtl/ctr_seal.sv
module ctr_seal #(
  parameter int DW  = 32,
  parameter int IDW = 3,
  parameter int HW  = DW / 2
) (
  input  logic [DW-1:0]  din,
  input  logic [DW-1:0]  key,
  input  logic [IDW-1:0] id,
  input  logic           unseal,
  output logic [DW-1:0]  plain,
  output logic [DW-1:0]  cipher,
  output logic [HW-1:0]  hash
);
  logic [HW-1:0] fold;

  always_comb begin
    plain  = unseal ? (din ^ key) : din;
    cipher = plain ^ key;
    fold   = (plain[DW-1:HW] ^ key[HW-1:0]) + (plain[HW-1:0] ^ key[DW-1:HW]);
    hash   = fold ^ (HW'(id) << 5);
  end
endmodule

// File: rtl/ctr_regs.sv
module ctr_regs #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int IDW  = 3,
  parameter int RAW  = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RAW-1:0] addr,
  output logic [DW-1:0]  rdata,
  output logic [IDW-1:0] rtag,
  input  logic           we,
  input  logic [DW-1:0]  wdata,
  input  logic [IDW-1:0] wtag
);
  logic [DW-1:0]  data_q [NREG];
  logic [IDW-1:0] tag_q  [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        data_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else if (we) begin
      data_q[addr] <= wdata;
      tag_q[addr]  <= wtag;
    end
  end

  assign rdata = data_q[addr];
  assign rtag  = tag_q[addr];
endmodule

// File: rtl/ctr_regfile.sv
module ctr_regfile
  import ctr_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int DW     = 32,
  parameter int NID    = 8,
  parameter int SUP_ID = 7,
  localparam int RAW   = $clog2(NREG),
  localparam int IDW   = $clog2(NID),
  localparam int HW    = DW / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [2:0]     cmd_op,
  input  logic [RAW-1:0] cmd_reg,
  input  logic [IDW-1:0] cmd_id,
  input  logic [DW-1:0]  cmd_data,
  input  logic [HW-1:0]  cmd_hash,
  input  logic           irq,
  output logic [IDW-1:0] cur_id,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data,
  output logic           acc_fault,
  output logic           sv_valid,
  output logic [DW-1:0]  sv_cipher,
  output logic [HW-1:0]  sv_hash,
  output logic [IDW-1:0] sv_owner,
  output logic           integ_fault,
  output logic           alloc_ok,
  output logic [IDW-1:0] alloc_id,
  output logic           kt_full
);
  op_t            op;
  logic [DW-1:0]  r_data, s_plain, s_cipher, lk_key, w_data;
  logic [IDW-1:0] r_tag, lk_id, w_tag, a_slot;
  logic [HW-1:0]  s_hash;
  logic [NID-1:0] kt_valid;
  logic           permit, hash_ok, we, a_hit;

  assign op      = cmd_valid ? op_t'(cmd_op) : OP_NOP;
  assign permit  = (r_tag == '0) || (r_tag == cur_id);
  assign lk_id   = (op == OP_SAVE) ? r_tag : cmd_id;
  assign hash_ok = (s_hash == cmd_hash);
  assign we      = ((op == OP_WRITE) && permit) || ((op == OP_RESTORE) && hash_ok);
  assign w_data  = (op == OP_WRITE) ? cmd_data : s_plain;
  assign w_tag   = (op == OP_WRITE) ? cur_id : cmd_id;

  ctr_regs #(.NREG(NREG), .DW(DW), .IDW(IDW)) u_regs (
    .clk(clk), .rst(rst), .addr(cmd_reg), .rdata(r_data), .rtag(r_tag),
    .we(we), .wdata(w_data), .wtag(w_tag));

  ctr_key_table #(.NID(NID), .DW(DW), .SUP_ID(SUP_ID)) u_keys (
    .clk(clk), .rst(rst), .irq(irq), .alloc_req(op == OP_ALLOC),
    .lk_id(lk_id), .lk_key(lk_key), .valid(kt_valid),
    .alloc_hit(a_hit), .alloc_slot(a_slot), .full(kt_full));

  ctr_seal #(.DW(DW), .IDW(IDW)) u_seal (
    .din((op == OP_RESTORE) ? cmd_data : r_data), .key(lk_key), .id(lk_id),
    .unseal(op == OP_RESTORE), .plain(s_plain), .cipher(s_cipher), .hash(s_hash));

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_id      <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      acc_fault   <= 1'b0;
      sv_valid    <= 1'b0;
      sv_cipher   <= '0;
      sv_hash     <= '0;
      sv_owner    <= '0;
      integ_fault <= 1'b0;
      alloc_ok    <= 1'b0;
      alloc_id    <= '0;
    end else begin
      rd_valid    <= 1'b0;
      acc_fault   <= 1'b0;
      sv_valid    <= 1'b0;
      integ_fault <= 1'b0;
      alloc_ok    <= 1'b0;
      case (op)
        OP_READ: begin
          rd_valid  <= 1'b1;
          rd_data   <= permit ? r_data : '0;
          acc_fault <= !permit;
        end
        OP_WRITE:   acc_fault <= !permit;
        OP_ENTER:   if (cmd_id != '0 && kt_valid[cmd_id]) cur_id <= cmd_id;
        OP_EXIT:    cur_id <= '0;
        OP_SAVE: begin
          sv_valid  <= 1'b1;
          sv_cipher <= s_cipher;
          sv_hash   <= s_hash;
          sv_owner  <= r_tag;
        end
        OP_RESTORE: integ_fault <= !hash_ok;
        OP_ALLOC: if (a_hit) begin
          alloc_ok <= 1'b1;
          alloc_id <= a_slot;
        end
        default: ;
      endcase
    end
  end

  p_refused_read_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && acc_fault) |-> (rd_data == '0));
  p_exit_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd4) |=> (cur_id == '0));
  p_one_result_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_valid, sv_valid, integ_fault, alloc_ok}));
  p_full_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 3'd7 && kt_full) |=> !alloc_ok);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> (!rd_valid && !sv_valid && !acc_fault && !integ_fault && !alloc_ok));
endmodule

// File: tb/ctr_regfile_test.sv
module ctr_regfile_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0, cmd_reg = '0, cmd_id = '0;
  logic [31:0] cmd_data = '0;
  logic [15:0] cmd_hash = '0;
  logic        irq = 1'b0;
  logic [2:0]  cur_id, sv_owner, alloc_id;
  logic        rd_valid, acc_fault, sv_valid, integ_fault, alloc_ok, kt_full;
  logic [31:0] rd_data, sv_cipher;
  logic [15:0] sv_hash;

  ctr_regfile uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_reg(cmd_reg),
    .cmd_id(cmd_id), .cmd_data(cmd_data), .cmd_hash(cmd_hash), .irq(irq),
    .cur_id(cur_id), .rd_valid(rd_valid), .rd_data(rd_data), .acc_fault(acc_fault),
    .sv_valid(sv_valid), .sv_cipher(sv_cipher), .sv_hash(sv_hash), .sv_owner(sv_owner),
    .integ_fault(integ_fault), .alloc_ok(alloc_ok), .alloc_id(alloc_id), .kt_full(kt_full));

  always #(PERIOD / 2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // Reference model state.
  logic [31:0] m_data [8];
  logic [2:0]  m_tag  [8];
  logic [31:0] m_key  [8];
  bit          m_valid [8];
  logic [2:0]  m_cur;
  logic        e_rd_valid, e_acc, e_sv_valid, e_integ, e_alloc_ok, e_full;
  logic [31:0] e_rd_data, e_sv_cipher;
  logic [15:0] e_sv_hash;
  logic [2:0]  e_sv_owner, e_alloc_id;
  logic [31:0] cap_c;
  logic [15:0] cap_h;
  logic [2:0]  cap_o;

  function automatic logic [15:0] f_hash(input logic [31:0] d, input logic [2:0] id,
                                         input logic [31:0] k);
    logic [15:0] s;
    s = (d[31:16] ^ k[15:0]) + (d[15:0] ^ k[31:16]);
    return s ^ ({13'd0, id} << 5);
  endfunction

  task automatic model_edge();
    logic [31:0] p;
    logic [2:0]  t;
    bit          found;
    if (rst) begin
      for (int i = 0; i < 8; i++) begin
        m_data[i] = 0; m_tag[i] = 0; m_key[i] = 32'h9E3779B9 * (i + 1);
        m_valid[i] = (i == 0) || (i == 7);
      end
      m_cur = 0; e_rd_valid = 0; e_acc = 0; e_sv_valid = 0; e_integ = 0; e_alloc_ok = 0;
      e_rd_data = 0; e_sv_cipher = 0; e_sv_hash = 0; e_sv_owner = 0; e_alloc_id = 0;
    end else begin
      e_rd_valid = 0; e_acc = 0; e_sv_valid = 0; e_integ = 0; e_alloc_ok = 0;
      if (cmd_valid) begin
        t = m_tag[cmd_reg];
        case (cmd_op)
          3'd1: begin
            e_rd_valid = 1;
            if (t == 0 || t == m_cur) e_rd_data = m_data[cmd_reg];
            else begin e_rd_data = 0; e_acc = 1; end
          end
          3'd2: if (t == 0 || t == m_cur) begin
                  m_data[cmd_reg] = cmd_data; m_tag[cmd_reg] = m_cur;
                end else e_acc = 1;
          3'd3: if (cmd_id != 0 && m_valid[cmd_id]) m_cur = cmd_id;
          3'd4: m_cur = 0;
          3'd5: begin
            e_sv_valid = 1; e_sv_owner = t;
            e_sv_cipher = m_data[cmd_reg] ^ m_key[t];
            e_sv_hash = f_hash(m_data[cmd_reg], t, m_key[t]);
          end
          3'd6: begin
            p = cmd_data ^ m_key[cmd_id];
            if (f_hash(p, cmd_id, m_key[cmd_id]) == cmd_hash) begin
              m_data[cmd_reg] = p; m_tag[cmd_reg] = cmd_id;
            end else e_integ = 1;
          end
          3'd7: begin
            found = 0;
            for (int i = 0; i < 8; i++)
              if (!found && !m_valid[i]) begin
                found = 1; m_valid[i] = 1; e_alloc_ok = 1; e_alloc_id = 3'(i);
              end
          end
          default: ;
        endcase
      end
      if (irq)
        for (int i = 0; i < 8; i++)
          m_key[i] = {m_key[i][30:0], m_key[i][31]} ^ 32'h9E3779B9;
    end
    e_full = 1;
    for (int i = 0; i < 8; i++) if (!m_valid[i]) e_full = 0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input bit in_reset);
    chk(in_reset ? "R1" : "R3", "rd_valid", 32'(rd_valid), 32'(e_rd_valid));
    chk(in_reset ? "R1" : "R3", "rd_data", rd_data, e_rd_data);
    chk(in_reset ? "R1" : "R2", "acc_fault", 32'(acc_fault), 32'(e_acc));
    chk(in_reset ? "R1" : "R5", "sv_valid", 32'(sv_valid), 32'(e_sv_valid));
    chk(in_reset ? "R1" : "R5", "sv_cipher", sv_cipher, e_sv_cipher);
    chk(in_reset ? "R1" : "R5", "sv_hash", 32'(sv_hash), 32'(e_sv_hash));
    chk(in_reset ? "R1" : "R5", "sv_owner", 32'(sv_owner), 32'(e_sv_owner));
    chk(in_reset ? "R1" : "R6", "integ_fault", 32'(integ_fault), 32'(e_integ));
    chk(in_reset ? "R1" : "R4", "cur_id", 32'(cur_id), 32'(m_cur));
    chk(in_reset ? "R1" : "R8", "alloc_ok", 32'(alloc_ok), 32'(e_alloc_ok));
    chk(in_reset ? "R1" : "R8", "alloc_id", 32'(alloc_id), 32'(e_alloc_id));
    chk(in_reset ? "R1" : "R8", "kt_full", 32'(kt_full), 32'(e_full));
  endtask

  // One clock: inputs already set at the falling edge.
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(rst);
    if (e_sv_valid) begin cap_c = e_sv_cipher; cap_h = e_sv_hash; cap_o = e_sv_owner; end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] r, input logic [2:0] id,
                     input logic [31:0] d, input logic [15:0] h, input bit intr);
    cmd_valid = 1; cmd_op = op; cmd_reg = r; cmd_id = id; cmd_data = d;
    cmd_hash = h; irq = intr;
    tick();
    cmd_valid = 0; irq = 0;
  endtask

  initial begin : watchdog
    #(PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] lfsr;
    @(negedge clk);
    rst = 1;
    tick(); tick(); tick();                       // R1 reset state
    rst = 0;
    tick();
    cmd(3'd2, 3'd1, 0, 32'hA5A5_0001, 0, 0);      // R2 write from ID 0
    // R9: output must not move before the sampling edge
    cmd_valid = 1; cmd_op = 3'd1; cmd_reg = 3'd1;
    #(PERIOD / 4);
    chk("R9", "rd_valid early", 32'(rd_valid), 32'd0);
    tick(); cmd_valid = 0;                        // R3 read returns data
    cmd(3'd7, 0, 0, 0, 0, 0);                     // R8 alloc -> 1
    cmd(3'd7, 0, 0, 0, 0, 0);                     // R8 alloc -> 2
    cmd(3'd3, 0, 3'd1, 0, 0, 0);                  // R4 enter 1
    cmd(3'd2, 3'd2, 0, 32'hDEAD_BEEF, 0, 0);      // R2 tagged write
    cmd(3'd1, 3'd2, 0, 0, 0, 0);                  // R3 own read
    cmd(3'd4, 0, 0, 0, 0, 0);                     // R4 exit
    cmd(3'd1, 3'd2, 0, 0, 0, 0);                  // R3 refused read
    cmd(3'd2, 3'd2, 0, 32'h1111_1111, 0, 0);      // R2 refused write
    cmd(3'd3, 0, 3'd2, 0, 0, 0);
    cmd(3'd1, 3'd2, 0, 0, 0, 0);                  // R3 other compartment refused
    cmd(3'd3, 0, 3'd5, 0, 0, 0);                  // R4 enter unallocated ignored
    cmd(3'd3, 0, 3'd7, 0, 0, 0);                  // supervisor
    cmd(3'd1, 3'd2, 0, 0, 0, 0);                  // R3 supervisor cannot read
    cmd(3'd5, 3'd2, 0, 0, 0, 0);                  // R5 save
    cmd(3'd6, 3'd3, cap_o, cap_c, cap_h ^ 16'h0001, 0); // R6 bad hash
    cmd(3'd6, 3'd3, cap_o, cap_c, cap_h, 0);      // R6 good restore
    cmd(3'd3, 0, 3'd1, 0, 0, 0);
    cmd(3'd1, 3'd3, 0, 0, 0, 0);                  // R6 restored value visible
    cmd(3'd3, 0, 3'd7, 0, 0, 0);
    cmd(3'd5, 3'd2, 0, 0, 0, 1);                  // R7 save with irq same cycle
    cmd(3'd6, 3'd4, cap_o, cap_c, cap_h, 0);      // R7 stale restore
    chk("R7", "stale tuple rejected", 32'(integ_fault), 32'd1);
    for (int i = 0; i < 6; i++) cmd(3'd7, 0, 0, 0, 0, 0); // R8 fill and overflow
    chk("R8", "table full", 32'(kt_full), 32'd1);
    lfsr = 32'hC0FF_EE01;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[2:0] == 3'd6)
        cmd(3'd6, lfsr[5:3], lfsr[7] ? cap_o : lfsr[10:8], cap_c,
            cap_h ^ {15'd0, lfsr[6]}, lfsr[15:12] == 0);
      else
        cmd(lfsr[2:0], lfsr[5:3], lfsr[10:8], lfsr, 16'(lfsr[31:16]), lfsr[15:12] == 0);
      if (lfsr[20:18] == 0) begin cmd_valid = 0; tick(); end
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule